// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic and Logic Slice

This block is the combinational heart of a bit-slice datapath. It picks two operands, R and S, from five candidates: the two register-file read latches (A and B), a direct data input D, an accumulator value Q, and a constant zero. It then applies one of eight operations to them. Three of the operations are arithmetic: an add and a subtract in each direction. Five are bitwise logic operations. The register file, the accumulator register, the shifters and any output drivers sit outside the block. Their values reach it only as plain inputs.

Several slices can be chained to form a wider word. The chaining can ripple carry-out into the next slice's carry-in. It can also use the exported active-low group generate and group propagate outputs with an external look-ahead carry unit. Each slice also reports its sign bit, a zero flag and a two's-complement overflow flag. The zero flags of several slices can be ANDed together outside the block to detect a zero across the whole word.

The block has no clock and no stored state. A result is valid once the inputs settle.

Top module: `alu_slice`

## Requirements
- R1: The source code `src_sel_i` picks the (R,S) pair: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0).
- R2: Function code 0 makes F = R + S + cin, modulo 16.
- R3: Function code 1 makes F = S + ~R + cin, modulo 16. This is S−R−1 when cin is low and S−R when cin is high.
- R4: Function code 2 makes F = R + ~S + cin, modulo 16. This is R−S−1 when cin is low and R−S when cin is high.
- R5: Function codes 3 to 7 give, in order: R OR S, R AND S, (NOT R) AND S, R XOR S, and R XNOR S.
- R6: For function codes 3 to 7, `cin_i` has no effect on F.
- R7: For arithmetic codes, `cout_o` is high exactly when the 4-bit addition of the effective (possibly inverted) operands plus cin carries out of bit 3.
- R8: For arithmetic codes, `ovr_o` is high exactly when the carry into bit 3 differs from the carry out of bit 3.
- R9: `zero_o` is high exactly when all bits of F are low.
- R10: `sign_o` equals F[3], not inverted.
- R11: For arithmetic codes, `gen_n_o` is low exactly when the effective operands generate a carry out with cin low. `prop_n_o` is low exactly when every bit position has at least one effective operand bit high.
- R12: For function codes 3 to 7, `cout_o` and `ovr_o` are low, and `gen_n_o` and `prop_n_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel_i | input | 3 | Operand pair select code |
| fn_sel_i | input | 3 | Operation select code |
| a_i | input | 4 | A-latch operand |
| b_i | input | 4 | B-latch operand |
| d_i | input | 4 | Direct data operand |
| q_i | input | 4 | Accumulator operand |
| cin_i | input | 1 | Carry-in, active high |
| f_o | output | 4 | Result |
| cout_o | output | 1 | Carry-out, active high |
| gen_n_o | output | 1 | Group generate, active low |
| prop_n_o | output | 1 | Group propagate, active low |
| sign_o | output | 1 | Most significant result bit |
| zero_o | output | 1 | High when the result is all zero |
| ovr_o | output | 1 | Two's-complement overflow |

## Verification
The assertions check several properties whenever the inputs change:
- the zero and sign flags match the result;
- logic operations leave the carry, overflow, generate and propagate outputs quiet;
- an AND with a zero operand gives zero;
- carry-out agrees with the generate and propagate outputs.

Only the bench's scenarios can show the rest. That covers the exact operand routing for each source code and the arithmetic results in each subtract direction with both carry-in values. It also covers the boundary operands all-zeros and all-ones, where carries and overflow change.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    typedef enum logic [2:0] {
        SRC_AQ = 3'd0,
        SRC_AB = 3'd1,
        SRC_ZQ = 3'd2,
        SRC_ZB = 3'd3,
        SRC_ZA = 3'd4,
        SRC_DA = 3'd5,
        SRC_DQ = 3'd6,
        SRC_DZ = 3'd7
    } src_e;

    typedef enum logic [2:0] {
        FN_ADD   = 3'd0,
        FN_SUBR  = 3'd1,
        FN_SUBS  = 3'd2,
        FN_OR    = 3'd3,
        FN_AND   = 3'd4,
        FN_NAND1 = 3'd5,
        FN_XOR   = 3'd6,
        FN_XNOR  = 3'd7
    } fn_e;

    function automatic logic fn_is_arith(input logic [2:0] code);
        return code < 3'd3;
    endfunction

endpackage

// File: rtl/alu_slice_opmux.sv
module alu_slice_opmux
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2:0]   src_sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] q_i,
    output logic [W-1:0] r_o,
    output logic [W-1:0] s_o
);
    localparam logic [W-1:0] ZERO = '0;

    // R1: operand pair routing
    always_comb begin
        unique case (src_e'(src_sel_i))
            SRC_AQ: begin r_o = a_i;  s_o = q_i;  end
            SRC_AB: begin r_o = a_i;  s_o = b_i;  end
            SRC_ZQ: begin r_o = ZERO; s_o = q_i;  end
            SRC_ZB: begin r_o = ZERO; s_o = b_i;  end
            SRC_ZA: begin r_o = ZERO; s_o = a_i;  end
            SRC_DA: begin r_o = d_i;  s_o = a_i;  end
            SRC_DQ: begin r_o = d_i;  s_o = q_i;  end
            SRC_DZ: begin r_o = d_i;  s_o = ZERO; end
        endcase
    end
endmodule

// File: rtl/alu_slice_core.sv
module alu_slice_core
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2:0]   fn_sel_i,
    input  logic [W-1:0] r_i,
    input  logic [W-1:0] s_i,
    input  logic         cin_i,
    output logic [W-1:0] f_o,
    output logic         arith_o,
    output logic         c_top_in_o,
    output logic         c_out_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);
    localparam int TOP = W - 1;

    logic [W-1:0] opa, opb;
    logic [W-1:0] bit_g, bit_p, sum;
    logic [W:0]   carry;
    logic [W-1:0] logic_f;

    assign arith_o = fn_is_arith(fn_sel_i);

    // complement-and-carry subtraction (R3, R4)
    always_comb begin
        unique case (fn_e'(fn_sel_i))
            FN_SUBR: begin opa = ~r_i; opb = s_i;  end
            FN_SUBS: begin opa = r_i;  opb = ~s_i; end
            default: begin opa = r_i;  opb = s_i;  end
        endcase
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_g[i] = opa[i] & opb[i];
        assign bit_p[i] = opa[i] | opb[i];
        assign sum[i]   = opa[i] ^ opb[i] ^ carry[i];
    end

    always_comb begin
        logic gacc;
        carry[0] = cin_i;
        gacc     = 1'b0;
        for (int i = 0; i < W; i++) begin
            carry[i+1] = bit_g[i] | (bit_p[i] & carry[i]);
            gacc       = bit_g[i] | (bit_p[i] & gacc);
        end
        grp_g_o = gacc;
        grp_p_o = &bit_p;
    end

    assign c_top_in_o = carry[TOP];
    assign c_out_o    = carry[W];

    // R5: bitwise operations
    always_comb begin
        unique case (fn_e'(fn_sel_i))
            FN_OR:    logic_f = r_i | s_i;
            FN_AND:   logic_f = r_i & s_i;
            FN_NAND1: logic_f = ~r_i & s_i;
            FN_XOR:   logic_f = r_i ^ s_i;
            FN_XNOR:  logic_f = ~(r_i ^ s_i);
            default:  logic_f = '0;
        endcase
    end

    assign f_o = arith_o ? sum : logic_f;
endmodule

// File: rtl/alu_slice_flags.sv
module alu_slice_flags #(
    parameter int W = 4
) (
    input  logic [W-1:0] f_i,
    input  logic         arith_i,
    input  logic         c_top_in_i,
    input  logic         c_out_i,
    input  logic         grp_g_i,
    input  logic         grp_p_i,
    output logic         cout_o,
    output logic         gen_n_o,
    output logic         prop_n_o,
    output logic         sign_o,
    output logic         zero_o,
    output logic         ovr_o
);
    assign zero_o   = (f_i == '0);
    assign sign_o   = f_i[W-1];
    assign cout_o   = arith_i & c_out_i;
    assign ovr_o    = arith_i & (c_top_in_i ^ c_out_i);
    assign gen_n_o  = ~(arith_i & grp_g_i);
    assign prop_n_o = ~(arith_i & grp_p_i);
endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
    parameter int W = 4
) (
    input  logic [2:0]   src_sel_i,
    input  logic [2:0]   fn_sel_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] d_i,
    input  logic [W-1:0] q_i,
    input  logic         cin_i,
    output logic [W-1:0] f_o,
    output logic         cout_o,
    output logic         gen_n_o,
    output logic         prop_n_o,
    output logic         sign_o,
    output logic         zero_o,
    output logic         ovr_o
);
    logic [W-1:0] r_op, s_op;
    logic         arith, c_top_in, c_out, grp_g, grp_p;

    alu_slice_opmux #(.W(W)) opmux_i (
        .src_sel_i (src_sel_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .d_i       (d_i),
        .q_i       (q_i),
        .r_o       (r_op),
        .s_o       (s_op)
    );

    alu_slice_core #(.W(W)) core_i (
        .fn_sel_i   (fn_sel_i),
        .r_i        (r_op),
        .s_i        (s_op),
        .cin_i      (cin_i),
        .f_o        (f_o),
        .arith_o    (arith),
        .c_top_in_o (c_top_in),
        .c_out_o    (c_out),
        .grp_g_o    (grp_g),
        .grp_p_o    (grp_p)
    );

    alu_slice_flags #(.W(W)) flags_i (
        .f_i        (f_o),
        .arith_i    (arith),
        .c_top_in_i (c_top_in),
        .c_out_i    (c_out),
        .grp_g_i    (grp_g),
        .grp_p_i    (grp_p),
        .cout_o     (cout_o),
        .gen_n_o    (gen_n_o),
        .prop_n_o   (prop_n_o),
        .sign_o     (sign_o),
        .zero_o     (zero_o),
        .ovr_o      (ovr_o)
    );
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
    parameter int W = 4
) (
    input logic [2:0]   src_sel_i,
    input logic [2:0]   fn_sel_i,
    input logic         cin_i,
    input logic [W-1:0] f_o,
    input logic         cout_o,
    input logic         gen_n_o,
    input logic         prop_n_o,
    input logic         sign_o,
    input logic         zero_o,
    input logic         ovr_o
);
    logic logic_op, zero_r_src;

    assign logic_op   = fn_sel_i >= 3'd3;
    assign zero_r_src = (src_sel_i == 3'd2) || (src_sel_i == 3'd3) ||
                        (src_sel_i == 3'd4) || (src_sel_i == 3'd7);

    always_comb begin
        assert_zero_flag_R9: assert (zero_o == (f_o == '0))
            else $error("zero flag disagrees with result");
        assert_sign_bit_R10: assert (sign_o == f_o[W-1])
            else $error("sign output disagrees with result MSB");
        if (logic_op) begin
            assert_logic_quiet_R12: assert (!cout_o && !ovr_o && gen_n_o && prop_n_o)
                else $error("carry outputs active during logic op");
        end
        if (fn_sel_i == 3'd4 && zero_r_src) begin
            assert_and_zero_src_R1: assert (f_o == '0)
                else $error("AND with zero operand not zero");
        end
        if (!logic_op && !gen_n_o) begin
            assert_gen_forces_carry_R11: assert (cout_o)
                else $error("generate active without carry-out");
        end
        if (!logic_op && gen_n_o && !prop_n_o) begin
            assert_prop_passes_cin_R7: assert (cout_o == cin_i)
                else $error("propagate path does not pass carry-in");
        end
    end
endmodule

bind alu_slice alu_slice_chk #(.W(W)) chk_i (
    .src_sel_i (src_sel_i),
    .fn_sel_i  (fn_sel_i),
    .cin_i     (cin_i),
    .f_o       (f_o),
    .cout_o    (cout_o),
    .gen_n_o   (gen_n_o),
    .prop_n_o  (prop_n_o),
    .sign_o    (sign_o),
    .zero_o    (zero_o),
    .ovr_o     (ovr_o)
);

// File: tb/alu_slice_tb_top.sv
module alu_slice_tb_top;

    typedef struct {
        logic [2:0] src;
        logic [2:0] fn;
        logic       cin;
        logic [3:0] f;
        logic       cout;
        logic       gen_n;
        logic       prop_n;
        logic       sign;
        logic       zero;
        logic       ovr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_sel, fn_sel;
    logic [3:0] a, b, d, q;
    logic       cin;
    logic [3:0] f;
    logic       cout, gen_n, prop_n, sign, zero, ovr;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    alu_slice dut_i (
        .src_sel_i (src_sel),
        .fn_sel_i  (fn_sel),
        .a_i       (a),
        .b_i       (b),
        .d_i       (d),
        .q_i       (q),
        .cin_i     (cin),
        .f_o       (f),
        .cout_o    (cout),
        .gen_n_o   (gen_n),
        .prop_n_o  (prop_n),
        .sign_o    (sign),
        .zero_o    (zero),
        .ovr_o     (ovr)
    );

    function automatic exp_t model(input logic [2:0] s_code, input logic [2:0] f_code,
                                   input logic [3:0] va, input logic [3:0] vb,
                                   input logic [3:0] vd, input logic [3:0] vq,
                                   input logic c);
        exp_t e;
        int r, s, x, y, tot;
        case (s_code)           // R1
            3'd0: begin r = va; s = vq; end
            3'd1: begin r = va; s = vb; end
            3'd2: begin r = 0;  s = vq; end
            3'd3: begin r = 0;  s = vb; end
            3'd4: begin r = 0;  s = va; end
            3'd5: begin r = vd; s = va; end
            3'd6: begin r = vd; s = vq; end
            default: begin r = vd; s = 0; end
        endcase
        e.src = s_code; e.fn = f_code; e.cin = c;
        e.cout = 1'b0; e.ovr = 1'b0; e.gen_n = 1'b1; e.prop_n = 1'b1;
        if (f_code < 3'd3) begin
            x = (f_code == 3'd1) ? 15 - r : r;   // R3
            y = (f_code == 3'd2) ? 15 - s : s;   // R4
            tot = x + y + int'(c);               // R2
            e.f    = tot[3:0];
            e.cout = tot >= 16;                  // R7
            e.ovr  = (x[3] == y[3]) && (e.f[3] != x[3]);  // R8
            e.gen_n  = !((x + y) >= 16);         // R11
            e.prop_n = !(((x | y) & 15) == 15);
        end else begin
            case (f_code)       // R5, R6, R12
                3'd3: e.f = 4'(r | s);
                3'd4: e.f = 4'(r & s);
                3'd5: e.f = 4'((15 - r) & s);
                3'd6: e.f = 4'(r ^ s);
                default: e.f = 4'(15 - (r ^ s));
            endcase
        end
        e.sign = e.f[3];            // R10
        e.zero = (e.f == 4'd0);     // R9
        return e;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp,
                       input exp_t e);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s src=%0d fn=%0d cin=%0d actual=%0h expected=%0h",
                     tag, what, e.src, e.fn, e.cin, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] s_code, input logic [2:0] f_code,
                         input logic [3:0] va, input logic [3:0] vb,
                         input logic [3:0] vd, input logic [3:0] vq, input logic c);
        @(posedge clk);
        src_sel = s_code; fn_sel = f_code;
        a = va; b = vb; d = vd; q = vq; cin = c;
        sb_q.push_back(model(s_code, f_code, va, vb, vd, vq, c));
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            string ftag;
            e = sb_q.pop_front();
            ftag = (e.fn == 3'd0) ? "R2" : (e.fn == 3'd1) ? "R3" :
                   (e.fn == 3'd2) ? "R4" : "R5/R6";
            chk(ftag, "F (R1 routing)", f, e.f, e);
            chk((e.fn < 3'd3) ? "R7" : "R12", "cout", cout, e.cout, e);
            chk((e.fn < 3'd3) ? "R8" : "R12", "ovr", ovr, e.ovr, e);
            chk((e.fn < 3'd3) ? "R11" : "R12", "gen_n", gen_n, e.gen_n, e);
            chk((e.fn < 3'd3) ? "R11" : "R12", "prop_n", prop_n, e.prop_n, e);
            chk("R10", "sign", sign, e.sign, e);
            chk("R9", "zero", zero, e.zero, e);
        end
    end

    initial begin
        src_sel = '0; fn_sel = '0; a = '0; b = '0; d = '0; q = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // quiescent state: all-zero inputs give F=0, zero high (R9, R2)
        drive(3'd0, 3'd0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
        // boundary: all ones, overflow/carry corner (R7, R8)
        drive(3'd1, 3'd0, 4'h7, 4'h1, 4'h0, 4'h0, 1'b0);
        drive(3'd1, 3'd0, 4'hF, 4'hF, 4'h0, 4'h0, 1'b1);
        drive(3'd1, 3'd1, 4'h0, 4'h8, 4'h0, 4'h0, 1'b0);
        // exhaustive codes, both carry-in values, patterned and random operands
        for (int k = 0; k < 20; k++) begin
            for (int sc = 0; sc < 8; sc++) begin
                for (int fc = 0; fc < 8; fc++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [3:0] va, vb, vd, vq;
                        if (k == 0)      begin va = 4'h0; vb = 4'h0; vd = 4'h0; vq = 4'h0; end
                        else if (k == 1) begin va = 4'hF; vb = 4'hF; vd = 4'hF; vq = 4'hF; end
                        else if (k == 2) begin va = 4'h1; vb = 4'h2; vd = 4'h4; vq = 4'h8; end
                        else begin
                            va = 4'($urandom); vb = 4'($urandom);
                            vd = 4'($urandom); vq = 4'($urandom);
                        end
                        drive(3'(sc), 3'(fc), va, vb, vd, vq, 1'(c));
                    end
                end
            end
        end
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule